// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block behaves like a small serial EEPROM on a three-wire synchronous bus with a chip select, a serial clock and separate data-in and data-out lines. All activity is sampled in the system clock domain. The bus inputs pass through a short synchronizer, and a rising serial-clock edge is detected while chip select is high. Each command is a start bit, a two-bit opcode and an address field, and a data field follows for the writing commands. The storage array is a register file. A write-enable latch guards it, and a self-timed programming interval follows every accepted write.

The data-out line is modelled as a value plus an output enable, and a low enable means high impedance. The line is released while a command is shifted in. It carries read data during a read. After an accepted write it carries a busy/ready status. One parameter chooses 16-bit words, with an 8-bit address field and 128 locations, or 8-bit words, with a 9-bit address field and 256 locations.

Top module: `sereeprom_slave`

## Requirements
- R1: While waiting for a command, zeros sampled on data-in are ignored. The first 1 is the start bit, and it is followed by a 2-bit opcode and then the address field, all MSB first.
- R2: With WORD16=1 the address field is 8 bits and the data field is 16 bits. With WORD16=0 they are 9 and 8 bits.
- R3: Opcode 01 writes the data field, sent MSB first, to the location given by the address bits below the MSB. The address MSB is ignored.
- R4: Opcode 00 with address top bits 11 sets the write-enable latch. Opcode 00 with top bits 00 clears it. Reset clears it.
- R5: With the latch clear, write and write-all commands leave the array unchanged and start no programming interval.
- R6: Opcode 00 with address top bits 01 takes a data field and writes it to every location.
- R7: The output enable is low while the start bit, opcode, address and data are being shifted in.
- R8: After an accepted write, while chip select is high, the output is enabled. It shows 0 for PROG_CYCLES system clocks and then 1, and the status stays until the next start bit is accepted.
- R9: While programming, start bits are ignored, so a complete write sent in that time has no effect.
- R10: Dropping chip select before the last data bit aborts the command and leaves the array unchanged.
- R11: Opcode 10 is a read. After the last address bit the output is enabled with a 0 dummy bit. Each later serial-clock rise presents the next bit of the word, MSB first.
- R12: After reset the output enable is low, the latch is clear and every location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled by clk |
| di | input | 1 | Serial data in |
| do_val | output | 1 | Serial data out value |
| do_oe | output | 1 | Data-out enable; low means high impedance |

## Verification
The assertions check on every cycle that the output stays released while a field is being shifted, and that losing chip select returns the frame logic to idle. They also check that no start bit is accepted while programming, that a programming interval begins only with the latch set, and that lock and unlock commands issued while busy leave the latch alone. What reaches the array cannot be seen by those properties. That needs the bench's scenarios, which read the array back through the read command: the ignored address MSB, write-all reaching far locations, aborted and locked writes, and the status line turning from busy to ready at the right time.

// File: rtl/sereeprom_pkg.sv
// Shared types and command codes for the serial EEPROM slave.
// Assumes: opcode and sub-opcode encodings are fixed by the bus protocol.
package sereeprom_pkg;
    typedef enum logic [2:0] {
        FR_IDLE,
        FR_OPC,
        FR_ADDR,
        FR_DATA,
        FR_READ,
        FR_DONE
    } frame_state_t;

    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;

    localparam logic [1:0] SUB_LOCK    = 2'b00;
    localparam logic [1:0] SUB_FILL    = 2'b01;
    localparam logic [1:0] SUB_UNLOCK  = 2'b11;
endpackage

// File: rtl/sereeprom_sync.sv
// Input conditioner: brings cs, sk and di into the clk domain through
// STAGES flops and flags a rising sk edge qualified by chip select.
// Assumes: sk half-periods last well over STAGES+1 clk cycles.
module sereeprom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise
);
    logic [STAGES-1:0] cs_p, sk_p, di_p;
    logic              sk_d;

    // Shift the raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p <= '0;
            sk_p <= '0;
            di_p <= '0;
            sk_d <= 1'b0;
        end else begin
            cs_p <= {cs_p[STAGES-2:0], cs};
            sk_p <= {sk_p[STAGES-2:0], sk};
            di_p <= {di_p[STAGES-2:0], di};
            sk_d <= sk_p[STAGES-1];
        end
    end

    assign cs_s    = cs_p[STAGES-1];
    assign di_s    = di_p[STAGES-1];
    assign sk_rise = cs_s & sk_p[STAGES-1] & ~sk_d;
endmodule

// File: rtl/sereeprom_frame.sv
// Command framer: finds the start bit, shifts in opcode, address and data,
// decodes the command and drives the data-out line (read data or status).
// Assumes: busy and rd_word come from the storage block; rd_word follows loc.
module sereeprom_frame
    import sereeprom_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          di_s,
    input  logic          sk_rise,
    input  logic          busy,
    input  logic          prog_start,
    input  logic [DW-1:0] rd_word,
    output logic [AW-2:0] loc,
    output logic [DW-1:0] wdata,
    output logic          cmd_write,
    output logic          cmd_fill,
    output logic          cmd_lock,
    output logic          cmd_unlock,
    output logic          do_val,
    output logic          do_oe
);
    localparam int MAXF = (AW > DW) ? AW : DW;
    localparam int CW   = $clog2(MAXF);

    frame_state_t  state;
    logic [CW-1:0] cnt;
    logic [1:0]    opc;
    logic [DW-1:0] rd_sh;
    logic          rd_first;
    logic          stat_show;

    logic [1:0]    opc_nx;
    logic [AW-1:0] addr_nx;
    logic [DW-1:0] data_nx;

    // Next values of the shift registers with the current bit appended.
    always_comb begin
        opc_nx  = {opc[0], di_s};
        addr_nx = {loc, di_s};
        data_nx = {wdata[DW-2:0], di_s};
    end

    // Frame sequencing, field shifting and command decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= FR_IDLE;
            cnt        <= '0;
            opc        <= '0;
            loc        <= '0;
            wdata      <= '0;
            rd_sh      <= '0;
            rd_first   <= 1'b0;
            stat_show  <= 1'b0;
            cmd_write  <= 1'b0;
            cmd_fill   <= 1'b0;
            cmd_lock   <= 1'b0;
            cmd_unlock <= 1'b0;
        end else begin
            cmd_write  <= 1'b0;
            cmd_fill   <= 1'b0;
            cmd_lock   <= 1'b0;
            cmd_unlock <= 1'b0;
            if (prog_start) begin
                stat_show <= 1'b1;
            end
            if (!cs_s) begin
                state <= FR_IDLE;
                cnt   <= '0;
            end else if (sk_rise) begin
                case (state)
                    FR_IDLE: begin
                        if (di_s && !busy) begin
                            state     <= FR_OPC;
                            cnt       <= '0;
                            stat_show <= 1'b0;
                        end
                    end
                    FR_OPC: begin
                        opc <= opc_nx;
                        if (cnt == CW'(1)) begin
                            state <= FR_ADDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FR_ADDR: begin
                        loc <= addr_nx[AW-2:0];
                        if (cnt == CW'(AW-1)) begin
                            cnt <= '0;
                            if (opc == OPC_WRITE) begin
                                state <= FR_DATA;
                            end else if (opc == OPC_READ) begin
                                state    <= FR_READ;
                                rd_first <= 1'b1;
                            end else if (opc == OPC_SPECIAL) begin
                                case (addr_nx[AW-1:AW-2])
                                    SUB_FILL:   state <= FR_DATA;
                                    SUB_LOCK:   begin state <= FR_DONE; cmd_lock   <= 1'b1; end
                                    SUB_UNLOCK: begin state <= FR_DONE; cmd_unlock <= 1'b1; end
                                    default:    state <= FR_DONE;
                                endcase
                            end else begin
                                state <= FR_DONE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FR_DATA: begin
                        wdata <= data_nx;
                        if (cnt == CW'(DW-1)) begin
                            state <= FR_DONE;
                            cnt   <= '0;
                            if (opc == OPC_WRITE) begin
                                cmd_write <= 1'b1;
                            end else begin
                                cmd_fill <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FR_READ: begin
                        if (rd_first) begin
                            rd_sh    <= rd_word;
                            rd_first <= 1'b0;
                        end else begin
                            rd_sh <= {rd_sh[DW-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Data-out: read stream in a read, otherwise busy/ready status.
    always_comb begin
        if (state == FR_READ) begin
            do_oe  = cs_s;
            do_val = rd_first ? 1'b0 : rd_sh[DW-1];
        end else begin
            do_oe  = cs_s && stat_show && (state == FR_IDLE || state == FR_DONE);
            do_val = !busy;
        end
    end

    assert_hiz_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_OPC || state == FR_ADDR || state == FR_DATA) |-> !do_oe);
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> state == FR_IDLE);
    assert_busy_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_IDLE && busy) |=> state == FR_IDLE);
endmodule

// File: rtl/sereeprom_store.sv
// Storage array, write-enable latch and programming timer.
// Assumes: command strobes are single-cycle; wr_idx and wr_data are stable
// during a strobe. Busy lasts PROG_CYCLES clk cycles after an accepted write.
module sereeprom_store #(
    parameter int IW          = 7,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_write,
    input  logic          cmd_fill,
    input  logic          cmd_lock,
    input  logic          cmd_unlock,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_word,
    output logic          busy,
    output logic          prog_start
);
    localparam int DEPTH = 1 << IW;
    localparam int TW    = $clog2(PROG_CYCLES + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [TW-1:0] timer;
    logic          wen;

    assign busy       = (timer != '0);
    assign prog_start = (cmd_write | cmd_fill) & wen & ~busy;
    assign rd_word    = mem[idx];

    // Write-enable latch; commands arriving while busy are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen <= 1'b0;
        end else if (!busy) begin
            if (cmd_unlock) begin
                wen <= 1'b1;
            end else if (cmd_lock) begin
                wen <= 1'b0;
            end
        end
    end

    // Programming interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (prog_start) begin
            timer <= TW'(PROG_CYCLES);
        end else if (busy) begin
            timer <= timer - 1'b1;
        end
    end

    // One register per location, written singly or all at once.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (prog_start && (cmd_fill || idx == IW'(g))) begin
                mem[g] <= wr_data;
            end
        end
    end

    assert_prog_needs_wen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen));
    assert_lock_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lock && !cmd_unlock && !busy) |=> !wen);
    assert_busy_keeps_wen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> wen == $past(wen));
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);
endmodule

// File: rtl/sereeprom_slave.sv
// Top: three-wire serial EEPROM slave. WORD16 picks 16-bit words (8-bit
// address field) or 8-bit words (9-bit address field).
// Assumes: sk is slow relative to clk; data-out tristate is done outside
// using do_oe.
module sereeprom_slave #(
    parameter bit WORD16      = 1'b1,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_val,
    output logic do_oe
);
    localparam int AW = WORD16 ? 8 : 9;
    localparam int DW = WORD16 ? 16 : 8;
    localparam int IW = AW - 1;

    logic          cs_s, di_s, sk_rise;
    logic          busy, prog_start;
    logic          cmd_write, cmd_fill, cmd_lock, cmd_unlock;
    logic [IW-1:0] loc;
    logic [DW-1:0] wdata, rd_word;

    sereeprom_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise)
    );

    sereeprom_frame #(.AW(AW), .DW(DW)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise),
        .busy(busy), .prog_start(prog_start), .rd_word(rd_word),
        .loc(loc), .wdata(wdata),
        .cmd_write(cmd_write), .cmd_fill(cmd_fill),
        .cmd_lock(cmd_lock), .cmd_unlock(cmd_unlock),
        .do_val(do_val), .do_oe(do_oe)
    );

    sereeprom_store #(.IW(IW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cmd_write(cmd_write), .cmd_fill(cmd_fill),
        .cmd_lock(cmd_lock), .cmd_unlock(cmd_unlock),
        .idx(loc), .wr_data(wdata), .rd_word(rd_word),
        .busy(busy), .prog_start(prog_start)
    );
endmodule

// File: tb/sim_sereeprom_slave.sv
module sim_sereeprom_slave;
    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_val, do_oe;

    int nvec = 0;
    int nfail = 0;
    logic [15:0] model [128];
    logic [15:0] exp_q [$];
    logic [15:0] act_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    sereeprom_slave #(.WORD16(1'b1), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .do_val(do_val), .do_oe(do_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops read results and compares them with the expected words.
    initial forever begin
        @(negedge clk);
        if (exp_q.size() > 0 && act_q.size() > 0) begin
            check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
        end
    end

    task automatic sk_pulse();
        repeat (4) @(posedge clk);
        sk = 1'b1;
        repeat (4) @(posedge clk);
        sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            di = v[i];
            sk_pulse();
        end
        di = 1'b0;
    endtask

    task automatic sel();
        cs = 1'b0;
        repeat (6) @(posedge clk);
        cs = 1'b1;
        repeat (6) @(posedge clk);
    endtask

    task automatic desel();
        cs = 1'b0;
        repeat (6) @(posedge clk);
    endtask

    // Driver: issues a read, pushes the expected word, collects the bits.
    task automatic rd(input logic [7:0] a, input string req);
        logic [15:0] w;
        sel();
        send(3'b110, 3);
        send(a, 8);
        @(negedge clk);
        check("R11 dummy", {14'd0, do_oe, do_val}, 16'h0002);
        for (int i = 15; i >= 0; i--) begin
            sk_pulse();
            @(negedge clk);
            w[i] = do_val;
        end
        exp_q.push_back(model[a[6:0]]);
        tag_q.push_back(req);
        act_q.push_back(w);
        desel();
    endtask

    task automatic special(input logic [1:0] sub);
        sel();
        send(3'b100, 3);
        send({sub, 6'b101010}, 8);
        desel();
    endtask

    initial begin
        for (int i = 0; i < 128; i++) model[i] = '0;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R12 oe after reset", {15'd0, do_oe}, 16'h0000);
        rd(8'h05, "R12 array zero");

        // R5: write with latch clear (reset state, R4) has no effect.
        sel();
        send(3'b101, 3); send(8'h03, 8); send(16'hA5A5, 16);
        repeat (4) @(posedge clk); @(negedge clk);
        check("R5 no status when locked", {15'd0, do_oe}, 16'h0000);
        desel();
        rd(8'h03, "R5 locked write ignored");

        // R4 unlock, then R1/R3 write with leading zeros and MSB set.
        special(2'b11);
        sel();
        send(3'b000, 3);
        send(3'b101, 3);
        send(4'h8, 4);
        @(negedge clk);
        check("R7 hiz in address", {15'd0, do_oe}, 16'h0000);
        send(4'h3, 4);
        send(8'h12, 8);
        @(negedge clk);
        check("R7 hiz in data", {15'd0, do_oe}, 16'h0000);
        send(8'h34, 8);
        model[3] = 16'h1234;
        repeat (4) @(posedge clk); @(negedge clk);
        check("R8 busy shown", {14'd0, do_oe, do_val}, 16'h0002);
        repeat (PROG) @(posedge clk); @(negedge clk);
        check("R8 ready shown", {14'd0, do_oe, do_val}, 16'h0003);
        desel();
        rd(8'h03, "R3 write, address MSB ignored (R1 R2)");

        // R9: complete write sent while busy is dropped.
        sel();
        send(3'b101, 3); send(8'h04, 8); send(16'h4444, 16);
        model[4] = 16'h4444;
        desel();
        sel();
        send(3'b101, 3); send(8'h05, 8); send(16'hBEEF, 16);
        @(negedge clk);
        check("R9 status still busy", {14'd0, do_oe, do_val}, 16'h0002);
        desel();
        repeat (PROG) @(posedge clk);
        rd(8'h05, "R9 write while busy ignored");
        rd(8'h04, "R9 first write kept");

        // R6: write-all.
        sel();
        send(3'b100, 3); send(8'h55, 8); send(16'h0F0F, 16);
        desel();
        for (int i = 0; i < 128; i++) model[i] = 16'h0F0F;
        repeat (PROG + 20) @(posedge clk);
        rd(8'h07, "R6 write-all low");
        rd(8'h7F, "R6 write-all top");

        // R10: abort mid data.
        sel();
        send(3'b101, 3); send(8'h09, 8); send(10'h3FF, 10);
        desel();
        @(negedge clk);
        check("R10 no status after abort", {15'd0, do_oe}, 16'h0000);
        repeat (PROG + 20) @(posedge clk);
        rd(8'h09, "R10 aborted write");

        // R4: lock, then write is ignored.
        special(2'b00);
        sel();
        send(3'b101, 3); send(8'h0A, 8); send(16'hAAAA, 16);
        repeat (4) @(posedge clk); @(negedge clk);
        check("R4 locked, no status", {15'd0, do_oe}, 16'h0000);
        desel();
        rd(8'h0A, "R4 relocked write ignored");

        repeat (20) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule